// File: doc/BRIEF.md
# Split Request/Response Protocol Transducer

This block joins a master that uses a blocking strobe/acknowledge handshake to a slave whose request and response travel on separate channels. The master holds `m_stb` and its fields steady and waits for `m_ack`. The slave takes request beats on a valid/ready channel. It returns responses later on its own channel, and each response carries the tag of the transfer it answers. The block supports single reads and writes, and bursts of `BURST_LEN` beats that carry one address.

Two state machines share the work. The request machine turns master beats into slave request beats and pushes them into a small FIFO. The FIFO head drives the slave request channel, so a slave that stalls does not freeze the logic on the master side. The response machine waits for responses carrying the tag of the transfer in flight. It returns read data to the master, and for a write it finishes the handshake once the write response arrives. Both machines leave from their idle state and come back to it for every kind of transfer.

Request machine states: RQ_IDLE (waits for a strobe and pushes the header beat), RQ_ACKED (the edge after an acknowledge, which is not sampled), RQ_BEAT (pushes the next burst-write data beat), RQ_WAIT (waits for the response machine). Transitions: IDLE→ACKED after the header of a burst write; IDLE→WAIT after any other header; ACKED→BEAT while burst beats remain; ACKED→IDLE otherwise; BEAT→ACKED after a beat that is not the last; BEAT→WAIT after the last beat; WAIT→ACKED when the response machine finishes. Response machine states: RS_IDLE, RS_WAIT, RS_GAP. Transitions: IDLE→WAIT when a header is pushed; WAIT→IDLE on the final matching response; WAIT→GAP on a matching read beat that is not the last; GAP→WAIT after one cycle.

Top module: `split_txn_bridge`

## Requirements
- R1: While reset is asserted, `m_ack` is 0, `s_req_valid` is 0 and `s_rsp_ready` is 1.
- R2: A single write (`m_we`=1, `m_burst`=0) produces one request beat with `s_req_hdr`=1, `s_req_we`=1, `s_req_burst`=0, the master address and the master write data. `m_ack` rises only in the cycle after the write response with the matching tag is taken.
- R3: A single read produces one header beat with `s_req_we`=0 and write data 0. In the cycle after the matching response is taken, `m_ack`=1 and `m_rdata` equals that response's data.
- R4: A burst write produces a header beat that carries beat 0 data, followed by `BURST_LEN`-1 beats with `s_req_hdr`=0, `s_req_we`=1, `s_req_burst`=1, address 0 and the same tag, in master order. Each of the first `BURST_LEN`-1 beats is acknowledged once it is queued. The last beat is acknowledged only after the write response.
- R5: A burst read produces exactly one header beat with `s_req_burst`=1. The next `BURST_LEN` matching responses are each acknowledged to the master in arrival order with their data. After each one except the last, `s_rsp_ready` is 0 for one cycle.
- R6: Tags start at 0 after reset and increase by 1 (mod 2^`TAG_W`) for each transfer. Every beat of a transfer carries that transfer's tag.
- R7: A response whose tag differs from the outstanding transfer, or that arrives with nothing outstanding, is taken (`s_rsp_ready`=1), causes no `m_ack` and leaves `m_rdata` unchanged.
- R8: When the FIFO holds `FIFO_DEPTH` beats, further master beats are neither queued nor acknowledged until the slave drains a beat. Beat order is kept.
- R9: While `s_req_valid`=1 and `s_req_ready`=0, `s_req_valid` stays high and every request field stays stable.
- R10: `m_ack` is never high in two consecutive cycles. The clock edge after each acknowledge does not sample the master, so the master can change its fields then.
- R11: Every transfer type returns to idle. A new strobe presented right after a final acknowledge starts the next transfer.
- R12: The master side is blocking. While a transfer is outstanding, a held strobe produces no further header beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_stb | input | 1 | Master strobe, held until the final acknowledge |
| m_we | input | 1 | Master write (1) or read (0) |
| m_burst | input | 1 | Master burst of BURST_LEN beats |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data for the current beat |
| m_ack | output | 1 | One-cycle beat acknowledge |
| m_rdata | output | DATA_W | Read data, valid with m_ack |
| s_req_valid | output | 1 | Request beat valid |
| s_req_ready | input | 1 | Slave takes the request beat |
| s_req_hdr | output | 1 | 1 for a header beat, 0 for a data beat |
| s_req_we | output | 1 | Write transfer |
| s_req_burst | output | 1 | Burst transfer |
| s_req_tag | output | TAG_W | Transfer tag |
| s_req_addr | output | ADDR_W | Address (0 on data beats) |
| s_req_wdata | output | DATA_W | Write data (0 on read headers) |
| s_rsp_valid | input | 1 | Response beat valid |
| s_rsp_ready | output | 1 | Bridge takes a response |
| s_rsp_tag | input | TAG_W | Tag of the response |
| s_rsp_data | input | DATA_W | Response data |

## Verification
Two events can fall on the same clock edge. The first is the FIFO taking a write-data beat from the request machine while the slave pops the head beat. The second is the response machine dropping a foreign-tag response while the request side is blocked on a full FIFO. The bench fills a two-entry FIFO with a burst write while the slave refuses beats, then releases it so that pushes and pops overlap. Every read carries a response with a wrong tag ahead of its real data. Results are judged from the logged order of the request beats, their tags and fields, and from how many acknowledges the master sees and when.

// File: rtl/spx_pkg.sv
package spx_pkg;
    typedef enum logic [1:0] {RQ_IDLE, RQ_BEAT, RQ_ACKED, RQ_WAIT} rq_state_t;
    typedef enum logic [1:0] {RS_IDLE, RS_WAIT, RS_GAP} rs_state_t;
endpackage

// File: rtl/req_beat_fifo.sv
module req_beat_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W:0] DEPTH_C = (PTR_W + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;

    assign full  = (count == DEPTH_C);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop) |=> (!empty && $stable(head)));
endmodule

// File: rtl/stb_req_fsm.sv
module stb_req_fsm
    import spx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 3,
    parameter int BURST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_stb,
    input  logic                m_we,
    input  logic                m_burst,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic [DATA_W-1:0]   m_wdata,
    input  logic                fifo_full,
    input  logic                rsp_done,
    output logic                push,
    output logic [3+TAG_W+ADDR_W+DATA_W-1:0] push_entry,
    output logic                start,
    output logic                start_we,
    output logic                start_burst,
    output logic [TAG_W-1:0]    start_tag,
    output logic                ack
);
    localparam int CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

    rq_state_t         state_q, state_d;
    logic [CNT_W-1:0]  beat_q, beat_d;
    logic [TAG_W-1:0]  next_tag_q, next_tag_d;
    logic [TAG_W-1:0]  cur_tag_q, cur_tag_d;
    logic              more_q, more_d;
    logic              ack_q, ack_d;

    assign start_we    = m_we;
    assign start_burst = m_burst;
    assign start_tag   = next_tag_q;
    assign ack         = ack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q     <= '0;
            next_tag_q <= '0;
            cur_tag_q  <= '0;
            more_q     <= 1'b0;
            ack_q      <= 1'b0;
        end else begin
            beat_q     <= beat_d;
            next_tag_q <= next_tag_d;
            cur_tag_q  <= cur_tag_d;
            more_q     <= more_d;
            ack_q      <= ack_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        beat_d     = beat_q;
        next_tag_d = next_tag_q;
        cur_tag_d  = cur_tag_q;
        more_d     = more_q;
        ack_d      = 1'b0;
        push       = 1'b0;
        push_entry = '0;
        start      = 1'b0;
        unique case (state_q)
            RQ_IDLE: begin
                if (m_stb && !fifo_full) begin
                    push       = 1'b1;
                    start      = 1'b1;
                    push_entry = {1'b1, m_we, m_burst, next_tag_q, m_addr,
                                  (m_we ? m_wdata : {DATA_W{1'b0}})};
                    cur_tag_d  = next_tag_q;
                    next_tag_d = next_tag_q + 1'b1;
                    if (m_we && m_burst) begin
                        beat_d  = CNT_W'(1);
                        more_d  = 1'b1;
                        ack_d   = 1'b1;
                        state_d = RQ_ACKED;
                    end else begin
                        state_d = RQ_WAIT;
                    end
                end
            end
            RQ_ACKED: begin
                state_d = more_q ? RQ_BEAT : RQ_IDLE;
            end
            RQ_BEAT: begin
                if (m_stb && !fifo_full) begin
                    push       = 1'b1;
                    push_entry = {1'b0, 1'b1, 1'b1, cur_tag_q, {ADDR_W{1'b0}}, m_wdata};
                    if (beat_q == LAST_BEAT) begin
                        state_d = RQ_WAIT;
                    end else begin
                        beat_d  = beat_q + 1'b1;
                        ack_d   = 1'b1;
                        state_d = RQ_ACKED;
                    end
                end
            end
            RQ_WAIT: begin
                if (rsp_done) begin
                    more_d  = 1'b0;
                    state_d = RQ_ACKED;
                end
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    a_r12_header_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == RQ_IDLE));
    a_r10_quiet_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> !push);
endmodule

// File: rtl/rsp_route_fsm.sv
module rsp_route_fsm
    import spx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 3,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic              start_burst,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic              s_rsp_valid,
    input  logic [TAG_W-1:0]  s_rsp_tag,
    input  logic [DATA_W-1:0] s_rsp_data,
    output logic              s_rsp_ready,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

    rs_state_t         state_q, state_d;
    logic [TAG_W-1:0]  exp_tag_q;
    logic              exp_we_q, exp_burst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q;
    logic              hit, last_beat, load;

    assign hit         = (state_q == RS_WAIT) && s_rsp_valid && (s_rsp_tag == exp_tag_q);
    assign last_beat   = exp_we_q || !exp_burst_q || (cnt_q == LAST_BEAT);
    assign load        = (state_q == RS_IDLE) && start;
    assign s_rsp_ready = (state_q != RS_GAP);
    assign done        = hit && last_beat;
    assign ack         = ack_q;
    assign rdata       = rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (start) state_d = RS_WAIT;
            RS_WAIT: if (hit)   state_d = last_beat ? RS_IDLE : RS_GAP;
            RS_GAP:             state_d = RS_WAIT;
            default:            state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_tag_q   <= '0;
            exp_we_q    <= 1'b0;
            exp_burst_q <= 1'b0;
            cnt_q       <= '0;
            ack_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            ack_q <= hit;
            if (hit) begin
                rdata_q <= s_rsp_data;
                cnt_q   <= cnt_q + 1'b1;
            end
            if (load) begin
                exp_tag_q   <= start_tag;
                exp_we_q    <= start_we;
                exp_burst_q <= start_burst;
                cnt_q       <= '0;
            end
        end
    end

    a_r7_foreign_tag_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rsp_valid && (s_rsp_tag != exp_tag_q)) |=> !ack_q);
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_q |-> $stable(rdata_q) || $past(hit));
    a_r5_gap_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !$past(last_beat)) |-> !s_rsp_ready);
endmodule

// File: rtl/split_txn_bridge.sv
module split_txn_bridge #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int TAG_W      = 3,
    parameter int BURST_LEN  = 4,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_stb,
    input  logic              m_we,
    input  logic              m_burst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ack,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_req_valid,
    input  logic              s_req_ready,
    output logic              s_req_hdr,
    output logic              s_req_we,
    output logic              s_req_burst,
    output logic [TAG_W-1:0]  s_req_tag,
    output logic [ADDR_W-1:0] s_req_addr,
    output logic [DATA_W-1:0] s_req_wdata,
    input  logic              s_rsp_valid,
    output logic              s_rsp_ready,
    input  logic [TAG_W-1:0]  s_rsp_tag,
    input  logic [DATA_W-1:0] s_rsp_data
);
    localparam int ENTRY_W = 3 + TAG_W + ADDR_W + DATA_W;

    logic               push, pop, fifo_full, fifo_empty;
    logic [ENTRY_W-1:0] push_entry, head;
    logic               start, start_we, start_burst;
    logic [TAG_W-1:0]   start_tag;
    logic               rsp_done, req_ack, rsp_ack;

    stb_req_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .BURST_LEN(BURST_LEN)
    ) u_req (
        .clk(clk), .rst_n(rst_n),
        .m_stb(m_stb), .m_we(m_we), .m_burst(m_burst),
        .m_addr(m_addr), .m_wdata(m_wdata),
        .fifo_full(fifo_full), .rsp_done(rsp_done),
        .push(push), .push_entry(push_entry),
        .start(start), .start_we(start_we), .start_burst(start_burst),
        .start_tag(start_tag), .ack(req_ack)
    );

    req_beat_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_entry), .pop(pop),
        .head(head), .full(fifo_full), .empty(fifo_empty)
    );

    rsp_route_fsm #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .BURST_LEN(BURST_LEN)
    ) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_we(start_we), .start_burst(start_burst),
        .start_tag(start_tag),
        .s_rsp_valid(s_rsp_valid), .s_rsp_tag(s_rsp_tag), .s_rsp_data(s_rsp_data),
        .s_rsp_ready(s_rsp_ready), .done(rsp_done),
        .ack(rsp_ack), .rdata(m_rdata)
    );

    assign s_req_valid = !fifo_empty;
    assign pop         = s_req_valid && s_req_ready;
    assign {s_req_hdr, s_req_we, s_req_burst, s_req_tag, s_req_addr, s_req_wdata} = head;
    assign m_ack       = req_ack | rsp_ack;

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |=> !m_ack);
    a_r10_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ack && rsp_ack));
    a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_valid && !s_req_ready) |=> s_req_valid);
    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_valid && !s_req_ready) |=> ($stable(s_req_tag) && $stable(s_req_addr)
                                          && $stable(s_req_wdata) && $stable(s_req_hdr)));
endmodule

// File: tb/test_split_txn_bridge.sv
module test_split_txn_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 16, TW = 3, BL = 4, FD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_stb = 0, m_we = 0, m_burst = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic m_ack;
    logic [DW-1:0] m_rdata;
    logic s_req_valid, s_req_ready = 1'b1, s_req_hdr, s_req_we, s_req_burst;
    logic [TW-1:0] s_req_tag;
    logic [AW-1:0] s_req_addr;
    logic [DW-1:0] s_req_wdata;
    logic s_rsp_valid = 0, s_rsp_ready;
    logic [TW-1:0] s_rsp_tag = '0;
    logic [DW-1:0] s_rsp_data = '0;

    split_txn_bridge #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .BURST_LEN(BL), .FIFO_DEPTH(FD))
    i_split_txn_bridge (
        .clk(clk), .rst_n(rst_n), .m_stb(m_stb), .m_we(m_we), .m_burst(m_burst),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_hdr(s_req_hdr),
        .s_req_we(s_req_we), .s_req_burst(s_req_burst), .s_req_tag(s_req_tag),
        .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
        .s_rsp_tag(s_rsp_tag), .s_rsp_data(s_rsp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, fails = 0, ack_cnt = 0, dbl_ack = 0, log_n = 0, xfer_idx = 0;
    bit prev_ack = 0, finished = 0;
    logic          lg_hdr [0:63];
    logic          lg_we  [0:63];
    logic          lg_bst [0:63];
    logic [TW-1:0] lg_tag [0:63];
    logic [AW-1:0] lg_addr[0:63];
    logic [DW-1:0] lg_data[0:63];

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_ack) begin
                ack_cnt++;
                if (prev_ack) dbl_ack++;
            end
            prev_ack = m_ack;
            if (s_req_valid && s_req_ready && log_n < 64) begin
                lg_hdr[log_n] = s_req_hdr;  lg_we[log_n]   = s_req_we;
                lg_bst[log_n] = s_req_burst; lg_tag[log_n] = s_req_tag;
                lg_addr[log_n] = s_req_addr; lg_data[log_n] = s_req_wdata;
                log_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ack(input string req);
        int n = 0;
        do begin @(negedge clk); n++; end while (!m_ack && n < 60);
        check(m_ack == 1'b1, req, 64'(m_ack), 64'd1);
    endtask

    task automatic wait_log(input int target, input string req);
        int n = 0;
        while (log_n < target && n < 60) begin @(negedge clk); n++; end
        check(log_n >= target, req, 64'(log_n), 64'(target));
    endtask

    task automatic send_rsp(input logic [TW-1:0] tag, input logic [DW-1:0] data);
        int n = 0;
        while (!s_rsp_ready && n < 60) begin @(negedge clk); n++; end
        s_rsp_valid = 1'b1; s_rsp_tag = tag; s_rsp_data = data;
        @(negedge clk);
        s_rsp_valid = 1'b0;
    endtask

    // checks the logged beats of one transfer (R2, R3, R4, R6, R11)
    task automatic check_log(input int n0, input bit we, input bit burst,
                             input logic [AW-1:0] addr, input logic [DW-1:0] base,
                             input logic [TW-1:0] t);
        int beats = (we && burst) ? BL : 1;
        check(lg_hdr[n0] == 1'b1 && lg_we[n0] == we && lg_bst[n0] == burst,
              "R2/R3 header kind", {lg_hdr[n0], lg_we[n0], lg_bst[n0]}, {1'b1, we, burst});
        check(lg_addr[n0] == addr, "R11 header address", 64'(lg_addr[n0]), 64'(addr));
        check(lg_tag[n0] == t, "R6 header tag", 64'(lg_tag[n0]), 64'(t));
        check(lg_data[n0] == (we ? base : '0), "R2/R3 header data", 64'(lg_data[n0]), 64'(we ? base : '0));
        for (int k = 1; k < beats; k++) begin
            check(lg_hdr[n0+k] == 1'b0 && lg_tag[n0+k] == t && lg_addr[n0+k] == '0,
                  "R4 data beat framing", {lg_hdr[n0+k], lg_tag[n0+k]}, {1'b0, t});
            check(lg_data[n0+k] == base + DW'(k), "R4 data beat order",
                  64'(lg_data[n0+k]), 64'(base + DW'(k)));
        end
    endtask

    task automatic do_xfer(input bit we, input bit burst, input logic [AW-1:0] addr,
                           input logic [DW-1:0] base);
        int beats = burst ? BL : 1;
        int n0 = log_n;
        int a0 = ack_cnt + (m_ack ? 1 : 0);
        logic [TW-1:0] t = TW'(xfer_idx);
        logic [DW-1:0] held;
        m_stb = 1'b1; m_we = we; m_burst = burst; m_addr = addr; m_wdata = base;
        if (we) begin
            for (int k = 0; k < beats - 1; k++) begin
                wait_ack("R4 beat ack");
                m_wdata = base + DW'(k + 1);
            end
            wait_log(n0 + beats, "R4 beats queued");
            repeat (2) @(negedge clk);
            check(ack_cnt == a0 + beats - 1 && !m_ack, "R2 no final ack before response",
                  64'(ack_cnt), 64'(a0 + beats - 1));
            send_rsp(t, 16'hd00d);
            check(m_ack == 1'b1, "R2 ack after write response", 64'(m_ack), 64'd1);
        end else begin
            wait_log(n0 + 1, "R3 header queued");
            repeat (3) @(negedge clk);
            check(log_n == n0 + 1, "R12 one header while blocked", 64'(log_n), 64'(n0 + 1));
            check(ack_cnt == a0, "R3 no ack before data", 64'(ack_cnt), 64'(a0));
            held = m_rdata;
            send_rsp(t + 1'b1, 16'hbad0);
            check(!m_ack && m_rdata == held, "R7 foreign tag dropped", {m_ack, m_rdata}, {1'b0, held});
            for (int k = 0; k < beats; k++) begin
                logic [DW-1:0] d = base + DW'(3 * k + 1);
                send_rsp(t, d);
                check(m_ack == 1'b1 && m_rdata == d, "R5 read beat data",
                      {m_ack, m_rdata}, {1'b1, d});
                if (k < beats - 1)
                    check(s_rsp_ready == 1'b0, "R5 ready gap", 64'(s_rsp_ready), 64'd0);
            end
        end
        check_log(n0, we, burst, addr, base, t);
        xfer_idx++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n0, a0;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        check(m_ack == 1'b0 && s_req_valid == 1'b0 && s_rsp_ready == 1'b1, "R1 reset state",
              {m_ack, s_req_valid, s_rsp_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: response with nothing outstanding
        held = m_rdata;
        send_rsp('0, 16'h7777);
        @(negedge clk);
        check(ack_cnt == 0 && m_rdata == held, "R7 idle response ignored",
              {32'(ack_cnt), m_rdata}, {32'd0, held});

        do_xfer(1'b1, 1'b0, 16'h0040, 16'h1234);   // R2
        do_xfer(1'b0, 1'b0, 16'h0044, 16'h2000);   // R3, R11 back-to-back

        // R8/R9: burst write into a two-entry FIFO with a stalled slave
        s_req_ready = 1'b0;
        n0 = log_n; a0 = ack_cnt + (m_ack ? 1 : 0);
        m_stb = 1; m_we = 1; m_burst = 1; m_addr = 16'h0080; m_wdata = 16'h5000;
        wait_ack("R8 header queued"); m_wdata = 16'h5001;
        wait_ack("R8 second beat queued"); m_wdata = 16'h5002;
        repeat (2) @(negedge clk);
        held = s_req_wdata;
        repeat (4) @(negedge clk);
        check(ack_cnt == a0 + 2 && log_n == n0, "R8 full FIFO stalls master",
              {32'(ack_cnt), 32'(log_n)}, {32'(a0 + 2), 32'(n0)});
        check(s_req_valid && s_req_wdata == held && s_req_addr == 16'h0080 && s_req_hdr,
              "R9 stalled head stable", {s_req_valid, s_req_wdata}, {1'b1, held});
        s_req_ready = 1'b1;
        wait_ack("R8 beat accepted after drain"); m_wdata = 16'h5003;
        wait_log(n0 + 4, "R8 all beats out");
        repeat (2) @(negedge clk);
        check(ack_cnt == a0 + 3, "R4 three beat acks", 64'(ack_cnt), 64'(a0 + 3));
        send_rsp(TW'(xfer_idx), 16'h0);
        check(m_ack == 1'b1, "R4 final ack after response", 64'(m_ack), 64'd1);
        check_log(n0, 1'b1, 1'b1, 16'h0080, 16'h5000, TW'(xfer_idx));
        xfer_idx++;

        // sweep of all four transfer kinds back to back, tags wrap (R6, R11)
        for (int i = 0; i < 10; i++)
            do_xfer(i[0], i[1], AW'(16'h0100 + 16 * i), DW'(16'h1000 * (i % 5) + i * 7));
        @(negedge clk);
        m_stb = 1'b0;
        repeat (4) @(negedge clk);
        check(dbl_ack == 0, "R10 ack never two cycles", 64'(dbl_ack), 64'd0);
        check(s_req_valid == 1'b0 && s_rsp_ready == 1'b1, "R11 idle at end",
              {s_req_valid, s_rsp_ready}, 2'b01);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule